// File: doc/BRIEF.md
# UART Register Bank with Interrupt Identification

This block is the host-facing register decoder of a PC-compatible serial port. A host reaches eight byte-wide registers through a 3-bit offset, with separate read and write strobes. The bank holds the interrupt enables, line control, modem control and scratch byte. It also holds a 16-bit baud divisor, which is reached through the data and enable offsets while line-control bit 7 is set. A write to the data offset goes to the transmitter as a one-cycle strobe carrying the byte. The transmitter is treated as always ready to accept it.

Received bytes enter an internal buffer. The buffer holds one byte while FIFO mode is off and `RX_DEPTH` bytes while it is on. The modem status unit follows either the external line levels or, in loopback, the modem-control outputs, and it latches change flags. From this state the bank derives a fixed-priority interrupt identification code and a registered, level-sensitive interrupt output.

In loopback, a byte written to the data offset goes into the receive buffer and not to the transmitter. Bytes arriving from the line are then discarded.

Top module: `ser_regbank`

## Requirements
- R1: After reset, the divisor is 12 (a 1.8432 MHz reference over 16 x 9600). Enables, line control, modem control and scratch are zero, the interrupt output is low, the identification register reads 0x01 and the line status register reads 0x60.
- R2: While line-control bit 7 is set, offset 0 reads and writes the divisor low byte and offset 1 the high byte, and `baud_div` shows {high, low}. The divisor changes only through these accesses.
- R3: Offset 1 (bit 7 clear) is the interrupt enable register and keeps only write bits 3:0: bit 0 receive data, bit 1 transmit empty, bit 2 overrun, bit 3 modem change. The upper bits read as 0.
- R4: A write to offset 2 is FIFO control. If bit 0 is 0, the stored value `fifo_ctl` becomes 0. If bit 0 is 1, it becomes wdata AND 0xC9, and bit 1 empties the receive buffer. Any change of bit 0 also empties the buffer. The buffer holds 1 byte while bit 0 is 0 and `RX_DEPTH` bytes while it is 1.
- R5: A read of offset 2 returns the identification code in bits 3:0, with bits 7:6 set when FIFO mode is on. The codes, in priority order: 0x6 for overrun with enable bit 2; 0xC for a non-empty buffer with enable bit 0; 0x2 for a pending transmit-empty with enable bit 1; 0x0 for any modem change flag with enable bit 3. Otherwise the code is 0x1.
- R6: Every data-offset write sets transmit-empty pending. A read of offset 2 that returns code 0x2 clears it.
- R7: A read of offset 5 returns bit 0 = buffer non-empty, bit 1 = overrun and bits 5 and 6 = 1, with all other bits 0. The read clears overrun unless a new overrun occurs in the same cycle.
- R8: When modem-control bit 4 (loopback) is set, a data write is pushed into the receive buffer and no transmit strobe is issued. A push the buffer cannot take sets overrun. Line bytes are ignored and `rx_ready` is low. The modem status bits follow modem control: CTS from bit 1, DSR from bit 0, RI from bit 2, DCD from bit 3.
- R9: With loopback clear, a data write raises `tx_strobe` for one cycle on the following clock, with `tx_byte` equal to the written value.
- R10: Offset 4 keeps write bits 4:0. A read of offset 6 returns the status levels in bits 7:4 (DCD, RI, DSR, CTS) and the change flags in bits 3:0. Bit 0 flags a CTS change, bit 1 a DSR change, bit 2 RI falling and bit 3 a DCD change. The read clears the flags unless a new change arrives in the same cycle.
- R11: Writes to offsets 5 and 6 change nothing. A data read with an empty buffer returns 0xFF and otherwise pops the oldest byte. Offset 7 is a free read/write byte.
- R12: `irq` is a register that is high exactly when the identification code for the state after each clock edge differs from 0x1.
- R13: A line byte offered with loopback clear while the buffer is at capacity is dropped and sets overrun. `rx_ready` is high exactly when loopback is clear and the buffer is below capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe (takes priority over read) |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of `rd_en` |
| tx_strobe | output | 1 | One-cycle transmit request |
| tx_byte | output | 8 | Byte to transmit |
| rx_push | input | 1 | A byte arrives from the line |
| rx_byte | input | 8 | Received line byte |
| rx_ready | output | 1 | Buffer can take a line byte |
| modem_in | input | 4 | Line levels {DCD, RI, DSR, CTS} |
| irq | output | 1 | Level interrupt request |
| baud_div | output | 16 | Current baud divisor |
| fifo_ctl | output | 8 | Stored FIFO control value |

## Verification
Most internal faults show up on the cycle after the access that causes them. A wrong overrun, pending or change flag shifts `irq` one clock later, and it changes the next read of offset 2, 5 or 6. A wrong buffer pointer or count shows either in `rx_ready` at once or as a wrong byte or 0xFF on the next data read. The bench runs a behavioural model with a byte queue in lockstep. It compares every read and every registered output on each clock, so a divergence is reported in the cycle where it first reaches a port.

// File: rtl/ser_pkg.sv
`timescale 1ns/1ps
package ser_pkg;

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_IER  = 3'd1;
    localparam logic [2:0] OFS_IIR  = 3'd2;
    localparam logic [2:0] OFS_LCR  = 3'd3;
    localparam logic [2:0] OFS_MCR  = 3'd4;
    localparam logic [2:0] OFS_LSR  = 3'd5;
    localparam logic [2:0] OFS_MSR  = 3'd6;
    localparam logic [2:0] OFS_SCR  = 3'd7;

    localparam logic [3:0] ID_NONE    = 4'h1;
    localparam logic [3:0] ID_LINE    = 4'h6;
    localparam logic [3:0] ID_RXDATA  = 4'hC;
    localparam logic [3:0] ID_TXEMPTY = 4'h2;
    localparam logic [3:0] ID_MODEM   = 4'h0;

    localparam int IEN_RX    = 0;
    localparam int IEN_TX    = 1;
    localparam int IEN_LINE  = 2;
    localparam int IEN_MODEM = 3;

    localparam int MC_DTR  = 0;
    localparam int MC_RTS  = 1;
    localparam int MC_AUX1 = 2;
    localparam int MC_AUX2 = 3;
    localparam int MC_LOOP = 4;

    localparam int LC_DLAB  = 7;
    localparam int FC_EN    = 0;
    localparam int FC_FLUSH = 1;
    localparam logic [7:0] FC_KEEP = 8'hC9;

    typedef struct packed {
        logic [3:0] ier;
        logic [7:0] lcr;
        logic [4:0] mcr;
        logic [7:0] scr;
        logic [7:0] div_lo;
        logic [7:0] div_hi;
        logic [7:0] fctl;
        logic       thre_pend;
        logic       overrun;
        logic       irq;
        logic       tx_stb;
        logic [7:0] tx_byte;
    } regs_t;

endpackage

// File: rtl/ser_rx_buffer.sv
`timescale 1ns/1ps
module ser_rx_buffer #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       big,
    input  logic       push,
    input  logic [7:0] push_data,
    input  logic       pop,
    output logic [7:0] head,
    output logic       not_empty,
    output logic       not_empty_next,
    output logic       has_room,
    output logic       reject
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CAP_BIG = CW'(DEPTH);
    localparam logic [CW-1:0] CAP_ONE = CW'(1);

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [CW-1:0] count;
    } ptr_t;

    ptr_t          st_d, st_q;
    logic [7:0]    mem_q [DEPTH];
    logic [CW-1:0] cap;
    logic          accept;
    logic          do_pop;

    always_comb begin
        cap       = big ? CAP_BIG : CAP_ONE;
        has_room  = st_q.count < cap;
        accept    = push && !flush && has_room;
        reject    = push && !flush && !has_room;
        do_pop    = pop && !flush && (st_q.count != '0);
        st_d      = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_pop) st_d.rd = st_q.rd + 1'b1;
            if (accept) st_d.wr = st_q.wr + 1'b1;
            st_d.count = st_q.count + CW'(accept) - CW'(do_pop);
        end
        head           = mem_q[st_q.rd];
        not_empty      = st_q.count != '0;
        not_empty_next = st_d.count != '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (accept) mem_q[st_q.wr] <= push_data;
    end

    AST_RX_SMALL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        !big |-> st_q.count <= CAP_ONE);                                   // R4
    AST_RX_WITHIN_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CAP_BIG);                                            // R13
    AST_RX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !not_empty);                                             // R4

endmodule

// File: rtl/ser_modem_status.sv
`timescale 1ns/1ps
module ser_modem_status
    import ser_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] mcr_next,
    input  logic [3:0] lines,
    input  logic       clr_delta,
    output logic [7:0] msr,
    output logic       delta_any_next
);
    typedef struct packed {
        logic [3:0] stat;
        logic [3:0] delta;
    } mst_t;

    mst_t       m_d, m_q;
    logic [3:0] eff;
    logic [3:0] chg;

    always_comb begin
        if (mcr_next[MC_LOOP])
            eff = {mcr_next[MC_AUX2], mcr_next[MC_AUX1], mcr_next[MC_DTR], mcr_next[MC_RTS]};
        else
            eff = lines;
        chg[0] = eff[0] ^ m_q.stat[0];
        chg[1] = eff[1] ^ m_q.stat[1];
        chg[2] = m_q.stat[2] & ~eff[2];
        chg[3] = eff[3] ^ m_q.stat[3];
        m_d.stat  = eff;
        m_d.delta = (clr_delta ? 4'h0 : m_q.delta) | chg;
        delta_any_next = m_d.delta != 4'h0;
        msr = {m_q.stat, m_q.delta};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    AST_MSR_RI_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(m_q.stat[2]) |-> m_q.delta[2]);                              // R10
    AST_MSR_DCD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.stat[3] != $past(m_q.stat[3])) |-> m_q.delta[3]);             // R10

endmodule

// File: rtl/ser_irq_prio.sv
`timescale 1ns/1ps
module ser_irq_prio
    import ser_pkg::*;
(
    input  logic [3:0] ien,
    input  logic       overrun,
    input  logic       rx_any,
    input  logic       thre,
    input  logic       modem_any,
    output logic [3:0] id
);
    always_comb begin
        if (overrun && ien[IEN_LINE])        id = ID_LINE;
        else if (rx_any && ien[IEN_RX])      id = ID_RXDATA;
        else if (thre && ien[IEN_TX])        id = ID_TXEMPTY;
        else if (modem_any && ien[IEN_MODEM]) id = ID_MODEM;
        else                                 id = ID_NONE;
    end
endmodule

// File: rtl/ser_regbank.sv
`timescale 1ns/1ps
module ser_regbank
    import ser_pkg::*;
#(
    parameter int RX_DEPTH = 16,
    parameter int REF_HZ   = 1843200,
    parameter int BAUD     = 9600
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  addr,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        tx_strobe,
    output logic [7:0]  tx_byte,
    input  logic        rx_push,
    input  logic [7:0]  rx_byte,
    output logic        rx_ready,
    input  logic [3:0]  modem_in,
    output logic        irq,
    output logic [15:0] baud_div,
    output logic [7:0]  fifo_ctl
);
    localparam logic [15:0] DIV_INIT = 16'(REF_HZ / (16 * BAUD));
    localparam regs_t RST_VAL = '{div_lo: DIV_INIT[7:0], div_hi: DIV_INIT[15:8], default: '0};

    regs_t      r_d, r_q;
    logic       wr, rd, dlab, loop;
    logic       lb_push, flush, pop, clr_msr;
    logic       buf_push;
    logic [7:0] buf_data;
    logic [7:0] head;
    logic       rx_any, rx_any_next, has_room, reject;
    logic [7:0] msr;
    logic       modem_any_next;
    logic [3:0] id_now, id_next;

    ser_rx_buffer #(.DEPTH(RX_DEPTH)) u_rxbuf (
        .clk(clk), .rst_n(rst_n), .flush(flush), .big(r_q.fctl[FC_EN]),
        .push(buf_push), .push_data(buf_data), .pop(pop), .head(head),
        .not_empty(rx_any), .not_empty_next(rx_any_next),
        .has_room(has_room), .reject(reject)
    );

    ser_modem_status u_modem (
        .clk(clk), .rst_n(rst_n), .mcr_next(r_d.mcr), .lines(modem_in),
        .clr_delta(clr_msr), .msr(msr), .delta_any_next(modem_any_next)
    );

    ser_irq_prio u_id_now (
        .ien(r_q.ier), .overrun(r_q.overrun), .rx_any(rx_any),
        .thre(r_q.thre_pend), .modem_any(msr[3:0] != 4'h0), .id(id_now)
    );

    ser_irq_prio u_id_next (
        .ien(r_d.ier), .overrun(r_d.overrun), .rx_any(rx_any_next),
        .thre(r_d.thre_pend), .modem_any(modem_any_next), .id(id_next)
    );

    // next-state logic
    always_comb begin
        wr      = wr_en;
        rd      = rd_en && !wr_en;
        dlab    = r_q.lcr[LC_DLAB];
        loop    = r_q.mcr[MC_LOOP];
        r_d     = r_q;
        r_d.tx_stb = 1'b0;
        lb_push = 1'b0;
        flush   = 1'b0;
        pop     = 1'b0;
        clr_msr = 1'b0;

        if (wr) begin
            case (addr)
                OFS_DATA: begin
                    if (dlab) begin
                        r_d.div_lo = wdata;
                    end else begin
                        r_d.thre_pend = 1'b1;
                        if (loop) begin
                            lb_push = 1'b1;
                        end else begin
                            r_d.tx_stb  = 1'b1;
                            r_d.tx_byte = wdata;
                        end
                    end
                end
                OFS_IER: begin
                    if (dlab) r_d.div_hi = wdata;
                    else      r_d.ier    = wdata[3:0];
                end
                OFS_IIR: begin
                    if (wdata[FC_EN] != r_q.fctl[FC_EN]) flush = 1'b1;
                    if (wdata[FC_EN]) begin
                        if (wdata[FC_FLUSH]) flush = 1'b1;
                        r_d.fctl = wdata & FC_KEEP;
                    end else begin
                        r_d.fctl = '0;
                    end
                end
                OFS_LCR: r_d.lcr = wdata;
                OFS_MCR: r_d.mcr = wdata[4:0];
                OFS_SCR: r_d.scr = wdata;
                default: ;
            endcase
        end

        if (rd) begin
            case (addr)
                OFS_DATA: if (!dlab) pop = 1'b1;
                OFS_IIR:  if (id_now == ID_TXEMPTY) r_d.thre_pend = 1'b0;
                OFS_LSR:  r_d.overrun = 1'b0;
                OFS_MSR:  clr_msr = 1'b1;
                default: ;
            endcase
        end

        buf_push = lb_push || (rx_push && !loop);
        buf_data = lb_push ? wdata : rx_byte;
        if (reject) r_d.overrun = 1'b1;
        r_d.irq = id_next != ID_NONE;
    end

    // read data
    always_comb begin
        rdata = 8'h00;
        if (rd) begin
            case (addr)
                OFS_DATA: rdata = dlab ? r_q.div_lo : (rx_any ? head : 8'hFF);
                OFS_IER:  rdata = dlab ? r_q.div_hi : {4'h0, r_q.ier};
                OFS_IIR:  rdata = {r_q.fctl[FC_EN] ? 2'b11 : 2'b00, 2'b00, id_now};
                OFS_LCR:  rdata = r_q.lcr;
                OFS_MCR:  rdata = {3'b000, r_q.mcr};
                OFS_LSR:  rdata = {1'b0, 1'b1, 1'b1, 3'b000, r_q.overrun, rx_any};
                OFS_MSR:  rdata = msr;
                OFS_SCR:  rdata = r_q.scr;
                default:  rdata = 8'hFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST_VAL;
        else        r_q <= r_d;
    end

    assign tx_strobe = r_q.tx_stb;
    assign tx_byte   = r_q.tx_byte;
    assign irq       = r_q.irq;
    assign baud_div  = {r_q.div_hi, r_q.div_lo};
    assign fifo_ctl  = r_q.fctl;
    assign rx_ready  = !r_q.mcr[MC_LOOP] && has_room;

    AST_THRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == OFS_IIR && rdata[3:0] == ID_TXEMPTY) |=> !r_q.thre_pend); // R6
    AST_OVERRUN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == OFS_LSR && !reject) |=> !r_q.overrun); // R7
    AST_NO_TX_IN_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> !$past(r_q.mcr[MC_LOOP]));                           // R8
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ier == 4'h0) |-> !irq);                                       // R12
    AST_DIV_NEEDS_DLAB: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(baud_div) |-> $past(r_q.lcr[LC_DLAB]));                   // R2

endmodule

// File: tb/sim_ser_regbank.sv
`timescale 1ns/1ps
module sim_ser_regbank;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  addr;
    logic        wr_en, rd_en, rx_push;
    logic [7:0]  wdata, rx_byte;
    logic [7:0]  rdata, tx_byte;
    logic        tx_strobe, rx_ready, irq;
    logic [3:0]  modem_in;
    logic [15:0] baud_div;
    logic [7:0]  fifo_ctl;

    always #2 clk = ~clk;

    ser_regbank #(.RX_DEPTH(16)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .tx_strobe(tx_strobe), .tx_byte(tx_byte),
        .rx_push(rx_push), .rx_byte(rx_byte), .rx_ready(rx_ready),
        .modem_in(modem_in), .irq(irq), .baud_div(baud_div), .fifo_ctl(fifo_ctl)
    );

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    logic [3:0] m_ier = 0;
    logic [7:0] m_lcr = 0, m_scr = 0, m_dll = 8'd12, m_dlh = 0, m_fctl = 0, m_txb = 0;
    logic [4:0] m_mcr = 0;
    logic       m_thre = 0, m_oe = 0, m_irq = 0, m_txs = 0;
    logic [3:0] m_st = 0, m_dlt = 0;
    logic [7:0] q[$];

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [3:0] m_reason();
        if (m_oe && m_ier[2])            return 4'h6;
        if (q.size() > 0 && m_ier[0])    return 4'hC;
        if (m_thre && m_ier[1])          return 4'h2;
        if (m_dlt != 0 && m_ier[3])      return 4'h0;
        return 4'h1;
    endfunction

    function automatic logic [7:0] m_read(logic [2:0] a);
        case (a)
            3'd0: return m_lcr[7] ? m_dll : (q.size() > 0 ? q[0] : 8'hFF);
            3'd1: return m_lcr[7] ? m_dlh : {4'h0, m_ier};
            3'd2: return {m_fctl[0] ? 2'b11 : 2'b00, 2'b00, m_reason()};
            3'd3: return m_lcr;
            3'd4: return {3'b000, m_mcr};
            3'd5: return {2'b01, 1'b1, 3'b000, m_oe, q.size() > 0};
            3'd6: return {m_st, m_dlt};
            default: return m_scr;
        endcase
    endfunction

    // one clock: drive at negedge, check read, update model, check registered outputs
    task automatic step(bit w, bit r, logic [2:0] a, logic [7:0] d, bit p, logic [7:0] pb, string tag);
        bit loop, dlab, rd, flush, lbp, pop, clr, oeclr, rej, pany;
        int cnt0, cap;
        logic [3:0] cur_id, eff;
        addr = a; wr_en = w; rd_en = r; wdata = d; rx_push = p; rx_byte = pb;
        #1;
        rd = r && !w;
        if (rd) chk(tag, "rdata", {8'h0, rdata}, {8'h0, m_read(a)});
        loop = m_mcr[4]; dlab = m_lcr[7];
        cur_id = m_reason(); cnt0 = q.size(); cap = m_fctl[0] ? 16 : 1;
        flush = 0; lbp = 0; pop = 0; clr = 0; oeclr = 0; rej = 0;
        m_txs = 0;
        if (w) begin
            case (a)
                3'd0: if (dlab) m_dll = d;
                      else begin m_thre = 1; if (loop) lbp = 1; else begin m_txs = 1; m_txb = d; end end
                3'd1: if (dlab) m_dlh = d; else m_ier = d[3:0];
                3'd2: begin
                    if (d[0] != m_fctl[0]) flush = 1;
                    if (d[0]) begin if (d[1]) flush = 1; m_fctl = d & 8'hC9; end
                    else m_fctl = 0;
                end
                3'd3: m_lcr = d;
                3'd4: m_mcr = d[4:0];
                3'd7: m_scr = d;
                default: ;
            endcase
        end
        if (rd) begin
            case (a)
                3'd0: if (!dlab) pop = 1;
                3'd2: if (cur_id == 4'h2) m_thre = 0;
                3'd5: oeclr = 1;
                3'd6: clr = 1;
                default: ;
            endcase
        end
        pany = lbp || (p && !loop);
        if (flush) q.delete();
        else begin
            if (pop && q.size() > 0) void'(q.pop_front());
            if (pany) begin
                if (cnt0 < cap) q.push_back(lbp ? d : pb);
                else rej = 1;
            end
        end
        if (oeclr) m_oe = 0;
        if (rej) m_oe = 1;
        eff = m_mcr[4] ? {m_mcr[3], m_mcr[2], m_mcr[0], m_mcr[1]} : modem_in;
        if (clr) m_dlt = 0;
        m_dlt = m_dlt | {eff[3] ^ m_st[3], m_st[2] & ~eff[2], eff[1] ^ m_st[1], eff[0] ^ m_st[0]};
        m_st = eff;
        m_irq = (m_reason() != 4'h1);
        @(posedge clk);
        @(negedge clk);
        chk("R12", "irq", {15'h0, irq}, {15'h0, m_irq});
        chk("R9", "tx_strobe", {15'h0, tx_strobe}, {15'h0, m_txs});
        if (m_txs) chk("R9", "tx_byte", {8'h0, tx_byte}, {8'h0, m_txb});
        chk("R2", "baud_div", baud_div, {m_dlh, m_dll});
        chk("R4", "fifo_ctl", {8'h0, fifo_ctl}, {8'h0, m_fctl});
        chk("R13", "rx_ready", {15'h0, rx_ready},
            {15'h0, !m_mcr[4] && (q.size() < (m_fctl[0] ? 16 : 1))});
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        step(1, 0, a, d, 0, 8'h00, "W");
    endtask
    task automatic rdr(logic [2:0] a, string tag);
        step(0, 1, a, 8'h00, 0, 8'h00, tag);
    endtask
    task automatic push(logic [7:0] b);
        step(0, 0, 3'd0, 8'h00, 1, b, "P");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; addr = 0; wr_en = 0; rd_en = 0; wdata = 0; rx_push = 0; rx_byte = 0; modem_in = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1", "irq", {15'h0, irq}, 16'h0);
        chk("R1", "baud_div", baud_div, 16'd12);
        chk("R1", "tx_strobe", {15'h0, tx_strobe}, 16'h0);
        rdr(3'd2, "R1"); rdr(3'd5, "R1"); rdr(3'd1, "R1"); rdr(3'd3, "R1"); rdr(3'd4, "R1");
        // R11 scratch, R3 mask
        wr(3'd7, 8'hA5); rdr(3'd7, "R11");
        wr(3'd1, 8'hFF); rdr(3'd1, "R3");
        // R2 divisor latch
        wr(3'd3, 8'h80); wr(3'd0, 8'h34); wr(3'd1, 8'h12);
        rdr(3'd0, "R2"); rdr(3'd1, "R2");
        wr(3'd3, 8'h03); rdr(3'd3, "R2"); rdr(3'd1, "R3");
        // R9 / R6 transmit and pending clear
        wr(3'd1, 8'h02); wr(3'd0, 8'h41);
        rdr(3'd2, "R6"); rdr(3'd2, "R6");
        // R13 single-byte capacity, R5 priority, R7 overrun
        wr(3'd1, 8'h05); push(8'h11); push(8'h22);
        rdr(3'd2, "R5"); rdr(3'd5, "R7"); rdr(3'd5, "R7"); rdr(3'd2, "R5");
        rdr(3'd0, "R11"); rdr(3'd0, "R11"); rdr(3'd2, "R5");
        // R4 FIFO mode
        wr(3'd2, 8'hC7); rdr(3'd2, "R4");
        for (int i = 0; i < 17; i++) push(8'(8'h30 + i));
        rdr(3'd5, "R13"); rdr(3'd0, "R4"); rdr(3'd0, "R4");
        wr(3'd2, 8'hC3); rdr(3'd5, "R4"); rdr(3'd0, "R4");
        push(8'h55); wr(3'd2, 8'h00); rdr(3'd2, "R4"); rdr(3'd0, "R4");
        // R8 / R10 loopback modem reflection
        wr(3'd1, 8'h08); wr(3'd4, 8'h1F);
        rdr(3'd2, "R5"); rdr(3'd6, "R8"); rdr(3'd6, "R10"); rdr(3'd4, "R10");
        wr(3'd4, 8'h1B); rdr(3'd6, "R10");
        // R8 loopback data
        wr(3'd1, 8'h01); wr(3'd0, 8'h5A); push(8'h77);
        rdr(3'd0, "R8"); rdr(3'd0, "R8");
        wr(3'd0, 8'h01); wr(3'd0, 8'h02); rdr(3'd5, "R8");
        // R11 ignored writes
        wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); rdr(3'd5, "R11"); rdr(3'd6, "R11");
        // R10 external lines
        wr(3'd4, 8'h00); wr(3'd1, 8'h08); rdr(3'd6, "R10");
        modem_in = 4'b0101; step(0, 0, 0, 0, 0, 0, "R10");
        rdr(3'd2, "R10"); rdr(3'd6, "R10");
        modem_in = 4'b0001; step(0, 0, 0, 0, 0, 0, "R10"); rdr(3'd6, "R10");
        // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            bit w, r, p;
            logic [2:0] a;
            logic [7:0] d;
            w = ($urandom_range(0, 3) == 0);
            r = ($urandom_range(0, 2) == 0);
            p = ($urandom_range(0, 2) == 0);
            a = 3'($urandom_range(0, 7));
            d = 8'($urandom_range(0, 255));
            if (w && a == 3'd3) d[7] = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 15) == 0) modem_in = 4'($urandom_range(0, 15));
            step(w, r, a, d, p, 8'($urandom_range(0, 255)), "R5");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule